// File: doc/BRIEF.md
# Configurable Two-Dimensional Product Code Encoder

This block turns a serial stream of information bits into a two-dimensional product codeword. The incoming bits fill an m-by-n array one row at a time. Each row is extended to l bits with an extended Hamming code. Each of the l resulting columns is then extended to k bits with the same kind of code. The finished k-by-l array leaves serially. It goes out row by row, or column by column when interleaving is selected. Both ends use ready/valid handshakes, and the output side may stall the block at any time.

The row length and the row count are each chosen from three sizes. The choice is taken from the configuration pins when the first bit of a block is accepted and is held for the rest of that block. Input ready stays low while a coded block is being read out, so a new block cannot overwrite one that is still in flight.

Top module: `tpc_encoder`

## Requirements
- R1: `cfgRowSel` sets the data bits per row n and `cfgColSel` sets the data row count m, with code 0 giving 11, code 1 giving 26 and code 2 giving 57. The matching coded lengths l (per row) and k (per column) are 16, 32 and 64, so an 11-row by 57-bit input yields a 16-by-64 output.
- R2: Component code for a data word of length d, where data bit i is the i-th bit in arrival or row order. Bit i is given Hamming position p(i), the i-th integer from 3 upward that is not a power of two. Coded bits 0..d-1 are the data bits. Coded bit d+j, for j from 0 to r-1 with r = 4, 5 or 6, is the XOR of the data bits whose p(i) has bit j set. The last coded bit is the XOR of all earlier coded bits.
- R3: Every one of the m data rows is row-encoded to l bits. Every one of the l columns, including the row-parity columns, is then column-encoded over its m entries to k bits. Array rows m..k-1 are column parity, and the corner holds the checks on checks.
- R4: With `cfgInterleave` low, the array is emitted row-major: row 0 bits 0..l-1, then row 1, and so on.
- R5: With `cfgInterleave` high, the array is emitted column-major: column 0 rows 0..k-1, then column 1, and so on.
- R6: Each block produces exactly k*l output transfers, and `outLast` is high on the final one only.
- R7: `inReady` is low from the cycle after the last input bit of a block is accepted until the final output bit is accepted, and it is high otherwise.
- R8: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` hold their values.
- R9: Configuration pins are sampled together with the first input bit of a block. Changes after that have no effect until the next block.
- R10: After reset, `inReady` is high and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRowSel | input | 2 | Data bits per row select (0:11, 1:26, 2:57) |
| cfgColSel | input | 2 | Data row count select (0:11, 1:26, 2:57) |
| cfgInterleave | input | 1 | 1 selects column-major readout |
| inValid | input | 1 | Input bit valid |
| inReady | output | 1 | Block accepts an input bit |
| inData | input | 1 | Serial information bit |
| outValid | output | 1 | Coded bit valid |
| outReady | input | 1 | Downstream accepts a coded bit |
| outData | output | 1 | Serial coded bit |
| outLast | output | 1 | Marks the final coded bit of a block |

## Verification
The bench sweeps all nine size pairs in both readout orders and adds all-zero, all-one and single-one blocks. A single one in the last data cell must light exactly its row parity, its column parity and the matching corner bits. A design that skipped the parity columns during column encoding, or misnumbered the Hamming positions, would corrupt exactly those bits. The configuration pins are scrambled after the first bit of every block, so a design that sampled them late would emit an array of the wrong shape and miscount its transfers. Output stalls are drawn at random, which exposes a readout counter that advances without a handshake or a data bit that changes during a stall.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int MAX_LEN = 64;
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int LEN_W   = IDX_W + 1;
  localparam int POS_W   = IDX_W;
  localparam int PAR_W   = $clog2(IDX_W + 1);

  typedef struct packed {
    logic             inFire;
    logic             rowEnd;
    logic             blockDone;
    logic [IDX_W-1:0] inCol;
    logic [IDX_W-1:0] inRow;
    logic [LEN_W-1:0] nLen;
    logic [LEN_W-1:0] lLen;
    logic [PAR_W-1:0] nPar;
    logic [LEN_W-1:0] mLen;
    logic [PAR_W-1:0] mPar;
    logic [IDX_W-1:0] rdRow;
    logic [IDX_W-1:0] rdCol;
  } tpcStrobe_t;

  function automatic logic [LEN_W-1:0] dataLen(input logic [1:0] sel);
    case (sel)
      2'd1:    return LEN_W'(26);
      2'd2:    return LEN_W'(57);
      default: return LEN_W'(11);
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] codeLen(input logic [1:0] sel);
    case (sel)
      2'd1:    return LEN_W'(32);
      2'd2:    return LEN_W'(64);
      default: return LEN_W'(16);
    endcase
  endfunction

  function automatic logic [PAR_W-1:0] parCnt(input logic [1:0] sel);
    case (sel)
      2'd1:    return PAR_W'(5);
      2'd2:    return PAR_W'(6);
      default: return PAR_W'(4);
    endcase
  endfunction

  // next Hamming position that is not a power of two
  function automatic logic [POS_W-1:0] nextPos(input logic [POS_W-1:0] p);
    logic [POS_W-1:0] q;
    q = p + POS_W'(1);
    if ((q & (q - POS_W'(1))) == '0) q = q + POS_W'(1);
    return q;
  endfunction

endpackage

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
  import tpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgRowSel,
  input  logic [1:0] cfgColSel,
  input  logic       cfgInterleave,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output logic       outLast,
  output tpcStrobe_t strb
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_READ} state_t;

  state_t           state;
  logic [1:0]       rowSelQ, colSelQ;
  logic             ilvQ;
  logic [1:0]       rowSelEff, colSelEff;
  logic             ilvEff;
  logic [IDX_W-1:0] inCol, inRow, rdRow, rdCol;
  logic [LEN_W-1:0] nLen, lLen, mLen, kLen;
  logic             inFire, rowEnd, lastIn, outFire, lastOut;

  assign rowSelEff = (state == S_IDLE) ? cfgRowSel     : rowSelQ;
  assign colSelEff = (state == S_IDLE) ? cfgColSel     : colSelQ;
  assign ilvEff    = (state == S_IDLE) ? cfgInterleave : ilvQ;

  assign nLen = dataLen(rowSelEff);
  assign lLen = codeLen(rowSelEff);
  assign mLen = dataLen(colSelEff);
  assign kLen = codeLen(colSelEff);

  assign inReady  = (state != S_READ);
  assign outValid = (state == S_READ);
  assign inFire   = inValid && inReady;
  assign outFire  = outValid && outReady;
  assign rowEnd   = inFire && ({1'b0, inCol} == nLen - LEN_W'(1));
  assign lastIn   = rowEnd && ({1'b0, inRow} == mLen - LEN_W'(1));
  assign lastOut  = ({1'b0, rdRow} == kLen - LEN_W'(1)) &&
                    ({1'b0, rdCol} == lLen - LEN_W'(1));
  assign outLast  = outValid && lastOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rowSelQ <= '0;
      colSelQ <= '0;
      ilvQ    <= 1'b0;
      inCol   <= '0;
      inRow   <= '0;
      rdRow   <= '0;
      rdCol   <= '0;
    end else begin
      if (state == S_IDLE && inFire) begin
        rowSelQ <= cfgRowSel;
        colSelQ <= cfgColSel;
        ilvQ    <= cfgInterleave;
        state   <= S_LOAD;
      end
      if (inFire) begin
        if (rowEnd) begin
          inCol <= '0;
          inRow <= inRow + IDX_W'(1);
        end else begin
          inCol <= inCol + IDX_W'(1);
        end
      end
      if (lastIn) begin
        state <= S_READ;
        inRow <= '0;
        rdRow <= '0;
        rdCol <= '0;
      end
      if (outFire) begin
        if (lastOut) begin
          state <= S_IDLE;
          rdRow <= '0;
          rdCol <= '0;
        end else if (ilvEff) begin
          if ({1'b0, rdRow} == kLen - LEN_W'(1)) begin
            rdRow <= '0;
            rdCol <= rdCol + IDX_W'(1);
          end else begin
            rdRow <= rdRow + IDX_W'(1);
          end
        end else begin
          if ({1'b0, rdCol} == lLen - LEN_W'(1)) begin
            rdCol <= '0;
            rdRow <= rdRow + IDX_W'(1);
          end else begin
            rdCol <= rdCol + IDX_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    strb.inFire    = inFire;
    strb.rowEnd    = rowEnd;
    strb.blockDone = outFire && lastOut;
    strb.inCol     = inCol;
    strb.inRow     = inRow;
    strb.nLen      = nLen;
    strb.lLen      = lLen;
    strb.nPar      = parCnt(rowSelEff);
    strb.mLen      = mLen;
    strb.mPar      = parCnt(colSelEff);
    strb.rdRow     = rdRow;
    strb.rdCol     = rdCol;
  end

endmodule

// File: rtl/tpc_datapath.sv
module tpc_datapath
  import tpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tpcStrobe_t strb,
  input  logic       inData,
  output logic       outData
);

  localparam logic [POS_W-1:0] FIRST_POS = POS_W'(3);

  logic [MAX_LEN-1:0] rowBuf;
  logic [POS_W-1:0]   parAcc;
  logic               xorAcc;
  logic [POS_W-1:0]   posReg;
  logic [POS_W-1:0]   rowPos;
  logic [MAX_LEN-1:0] mem [MAX_LEN];
  logic [POS_W-1:0]   colPar [MAX_LEN];
  logic [MAX_LEN-1:0] colXor;

  logic [POS_W-1:0]   parFull;
  logic               xorFull;
  logic [MAX_LEN-1:0] dataFull;
  logic [MAX_LEN-1:0] rowWord;
  logic [LEN_W-1:0]   lastIdx;

  assign parFull = parAcc ^ (inData ? posReg : '0);
  assign xorFull = xorAcc ^ inData;
  assign lastIdx = strb.lLen - LEN_W'(1);

  always_comb begin
    dataFull = rowBuf;
    dataFull[strb.inCol] = inData;
  end

  // completed row: data bits, Hamming bits, overall parity
  always_comb begin
    logic [LEN_W-1:0] wIdx;
    rowWord = '0;
    for (int c = 0; c < MAX_LEN; c++) begin
      if (LEN_W'(c) < strb.nLen) rowWord[c] = dataFull[c];
    end
    for (int j = 0; j < POS_W; j++) begin
      wIdx = strb.nLen + LEN_W'(j);
      if (PAR_W'(j) < strb.nPar) rowWord[wIdx[IDX_W-1:0]] = parFull[j];
    end
    rowWord[lastIdx[IDX_W-1:0]] = xorFull ^ (^parFull);
  end

  always_ff @(posedge clk) begin
    if (strb.rowEnd) mem[strb.inRow] <= rowWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowBuf <= '0;
      parAcc <= '0;
      xorAcc <= 1'b0;
      posReg <= FIRST_POS;
      rowPos <= FIRST_POS;
      colXor <= '0;
      for (int c = 0; c < MAX_LEN; c++) colPar[c] <= '0;
    end else begin
      if (strb.inFire) begin
        rowBuf[strb.inCol] <= inData;
        if (strb.rowEnd) begin
          parAcc <= '0;
          xorAcc <= 1'b0;
          posReg <= FIRST_POS;
          rowPos <= nextPos(rowPos);
          for (int c = 0; c < MAX_LEN; c++) begin
            colPar[c] <= colPar[c] ^ (rowWord[c] ? rowPos : '0);
            colXor[c] <= colXor[c] ^ rowWord[c];
          end
        end else begin
          parAcc <= parFull;
          xorAcc <= xorFull;
          posReg <= nextPos(posReg);
        end
      end
      if (strb.blockDone) begin
        rowPos <= FIRST_POS;
        colXor <= '0;
        for (int c = 0; c < MAX_LEN; c++) colPar[c] <= '0;
      end
    end
  end

  // readout: data rows from storage, parity rows from accumulators
  always_comb begin
    logic [LEN_W-1:0] pIdx;
    logic [POS_W-1:0] cp;
    cp   = colPar[strb.rdCol];
    pIdx = {1'b0, strb.rdRow} - strb.mLen;
    if ({1'b0, strb.rdRow} < strb.mLen)
      outData = mem[strb.rdRow][strb.rdCol];
    else if (pIdx < LEN_W'(strb.mPar))
      outData = cp[pIdx[PAR_W-1:0]];
    else
      outData = colXor[strb.rdCol] ^ (^cp);
  end

endmodule

// File: rtl/tpc_encoder.sv
module tpc_encoder
  import tpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgRowSel,
  input  logic [1:0] cfgColSel,
  input  logic       cfgInterleave,
  input  logic       inValid,
  output logic       inReady,
  input  logic       inData,
  output logic       outValid,
  input  logic       outReady,
  output logic       outData,
  output logic       outLast
);

  tpcStrobe_t strb;

  tpc_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgRowSel     (cfgRowSel),
    .cfgColSel     (cfgColSel),
    .cfgInterleave (cfgInterleave),
    .inValid       (inValid),
    .inReady       (inReady),
    .outValid      (outValid),
    .outReady      (outReady),
    .outLast       (outLast),
    .strb          (strb)
  );

  tpc_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/tpc_encoder_chk.sv
module tpc_encoder_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic outReady,
  input logic outData,
  input logic outLast
);

  a_r7_no_input_during_readout: assert property (
    @(posedge clk) disable iff (!rstN) outValid |-> !inReady);

  a_r7_ready_after_last: assert property (
    @(posedge clk) disable iff (!rstN) (outValid && outReady && outLast) |=> inReady);

  a_r8_hold_valid: assert property (
    @(posedge clk) disable iff (!rstN) (outValid && !outReady) |=> outValid);

  a_r8_hold_payload: assert property (
    @(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outData) && $stable(outLast)));

  a_r6_last_is_valid: assert property (
    @(posedge clk) disable iff (!rstN) outLast |-> outValid);

  a_r7_input_accept_no_output: assert property (
    @(posedge clk) disable iff (!rstN) (inValid && inReady) |-> !outValid);

endmodule

bind tpc_encoder tpc_encoder_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outLast  (outLast)
);

// File: tb/tb_tpc_encoder.sv
module tb_tpc_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cfgRowSel = 2'd0;
  logic [1:0] cfgColSel = 2'd0;
  logic       cfgInterleave = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       inData = 1'b0;
  logic       outValid;
  logic       outReady = 1'b0;
  logic       outData;
  logic       outLast;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  int dat  [64][64];
  int gold [64][64];
  int dLen [3] = '{11, 26, 57};
  int cLen [3] = '{16, 32, 64};

  always #(CLK_PERIOD/2) clk = ~clk;

  tpc_encoder dut (
    .clk           (clk),
    .rstN          (rstN),
    .cfgRowSel     (cfgRowSel),
    .cfgColSel     (cfgColSel),
    .cfgInterleave (cfgInterleave),
    .inValid       (inValid),
    .inReady       (inReady),
    .inData        (inData),
    .outValid      (outValid),
    .outReady      (outReady),
    .outData       (outData),
    .outLast       (outLast)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: i-th integer from 3 upward that is not a power of two
  function automatic int hamPos(input int i);
    int p = 2;
    int c = -1;
    while (c < i) begin
      p++;
      if ((p & (p - 1)) != 0) c++;
    end
    return p;
  endfunction

  // R2: encode vec[0..d-1] into vec[0..len-1]
  task automatic encodeVec(ref int vec[64], input int d, input int len);
    int r = len - d - 1;
    int x;
    for (int j = 0; j < r; j++) begin
      x = 0;
      for (int i = 0; i < d; i++)
        if (vec[i] != 0 && ((hamPos(i) >> j) & 1) != 0) x ^= 1;
      vec[d + j] = x;
    end
    x = 0;
    for (int i = 0; i < len - 1; i++) x ^= vec[i];
    vec[len - 1] = x;
  endtask

  // R3: rows first, then every column of the row-coded array
  task automatic buildGold(input int m, input int n, input int k, input int l);
    int vec [64];
    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) gold[r][c] = 0;
    for (int r = 0; r < m; r++) begin
      for (int c = 0; c < 64; c++) vec[c] = (c < n) ? dat[r][c] : 0;
      encodeVec(vec, n, l);
      for (int c = 0; c < l; c++) gold[r][c] = vec[c];
    end
    for (int c = 0; c < l; c++) begin
      for (int r = 0; r < 64; r++) vec[r] = (r < m) ? gold[r][c] : 0;
      encodeVec(vec, m, k);
      for (int r = 0; r < k; r++) gold[r][c] = vec[r];
    end
  endtask

  task automatic runBlock(input int rs, input int cs, input int ilv,
                          input int pat, input int bp);
    int n = dLen[rs];
    int m = dLen[cs];
    int l = cLen[rs];
    int k = cLen[cs];
    int total = m * n;
    int kl = k * l;
    int beats = 0;
    bit gotLast = 1'b0;
    bit prevStall = 1'b0;
    int prevData = 0;
    int prevLast = 0;

    for (int r = 0; r < 64; r++)
      for (int c = 0; c < 64; c++) begin
        case (pat)
          1:       dat[r][c] = 0;
          2:       dat[r][c] = 1;
          3:       dat[r][c] = (r == m - 1 && c == n - 1) ? 1 : 0;
          default: dat[r][c] = $urandom % 2;
        endcase
      end
    buildGold(m, n, k, l);

    @(negedge clk);
    cfgRowSel     = 2'(rs);
    cfgColSel     = 2'(cs);
    cfgInterleave = ilv[0];

    fork
      begin : driver
        int idx = 0;
        while (idx < total) begin
          @(negedge clk);
          if (idx >= 1) begin
            // R9: scramble configuration once the block has started
            cfgRowSel     = 2'((rs + 1 + idx % 2) % 3);
            cfgColSel     = 2'((cs + 2) % 3);
            cfgInterleave = ~ilv[0];
          end
          inValid = ($urandom % 4) != 0;
          inData  = dat[idx / n][idx % n][0];
          if (inValid && inReady) idx++;
        end
        @(negedge clk);
        inValid = 1'b0;
      end
      begin : receiver
        int er, ec;
        while (!gotLast && beats <= kl + 2) begin
          @(negedge clk);
          outReady = bp != 0 ? ($urandom % 2 == 1) : 1'b1;
          if (outValid) begin
            chk(inReady == 1'b0, "R7 inReady low in readout", int'(inReady), 0);
            if (prevStall) begin
              chk(int'(outData) == prevData, "R8 data held in stall", int'(outData), prevData);
              chk(int'(outLast) == prevLast, "R8 last held in stall", int'(outLast), prevLast);
            end
          end
          prevStall = outValid && !outReady;
          prevData  = int'(outData);
          prevLast  = int'(outLast);
          if (outValid && outReady) begin
            if (ilv != 0) begin
              ec = beats / k;
              er = beats % k;
            end else begin
              er = beats / l;
              ec = beats % l;
            end
            if (ilv != 0)
              chk(int'(outData) == gold[er][ec], "R5 column-major coded bit",
                  int'(outData), gold[er][ec]);
            else
              chk(int'(outData) == gold[er][ec], "R4 row-major coded bit",
                  int'(outData), gold[er][ec]);
            chk(int'(outLast) == ((beats == kl - 1) ? 1 : 0), "R6 last flag position",
                int'(outLast), (beats == kl - 1) ? 1 : 0);
            if (outLast) gotLast = 1'b1;
            beats++;
          end
        end
        chk(beats == kl, "R1 R6 R9 transfer count k*l", beats, kl);
        @(negedge clk);
        outReady = 1'b0;
        chk(inReady == 1'b1, "R7 inReady back after last", int'(inReady), 1);
        chk(outValid == 1'b0, "R6 no output after last", int'(outValid), 0);
      end
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(inReady == 1'b1, "R10 inReady in reset", int'(inReady), 1);
    chk(outValid == 1'b0, "R10 outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R10 inReady after reset", int'(inReady), 1);
    chk(outValid == 1'b0, "R10 outValid after reset", int'(outValid), 0);

    // R1 R3 R4 R5: every size pair in both readout orders
    for (int ilv = 0; ilv < 2; ilv++)
      for (int rs = 0; rs < 3; rs++)
        for (int cs = 0; cs < 3; cs++)
          runBlock(rs, cs, ilv, 0, (rs + cs + ilv) % 2);

    // R2 R3 corner patterns
    runBlock(0, 0, 0, 2, 0);
    runBlock(2, 1, 1, 3, 1);
    runBlock(0, 2, 0, 1, 1);
    runBlock(2, 0, 1, 3, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule